// File: doc/BRIEF.md
# Encoded Interrupt Level Decoder

This block sits in front of an interrupt controller. It takes a 4-bit encoded interrupt level from outside the chip and turns it into a request on one of 15 internal interrupt sources. The sources form an ordered chain. The level code picks one position on that chain, and the block drives a one-bit request and a one-bit enable override for every position.

Code 0 means that no interrupt is requested. Codes 1 through 15 run from the lowest priority to the highest. The chain position is the bitwise complement of the code, so the most urgent code lands on position 0.

When a position is chosen, its request is raised and its enable is forced on. The enable stays on after that point. Every other request is dropped at the same edge. Both output vectors are registered.

The controller downstream resolves priority between the sources. This block does not.

Top module: `enc_level_decoder`

## Requirements
- R1: While reset is active and right after it is released, every bit of `src_assert_o` and `src_force_en_o` is 0.
- R2: A nonzero level code L held at a rising edge makes `src_assert_o` equal to a vector with only bit (L XOR 15) set after that edge. Code 15 selects bit 0, and code 1 selects bit 14.
- R3: Level code 0 at a rising edge makes every bit of `src_assert_o` 0 after that edge.
- R4: At most one bit of `src_assert_o` is 1 at any time.
- R5: The outputs change only at a rising clock edge. A level change between edges does not show on the outputs until the next edge. A level held steady keeps the outputs steady.
- R6: The force-enable bit of a selected position becomes 1 at the edge where that position is selected. It stays 1 until reset, even after the request is dropped.
- R7: When the level changes from one nonzero code to another, the old position's request is dropped at the same edge that raises the new one.
- R8: The force-enable bits of positions that have not been selected since reset stay 0. Level code 0 leaves `src_force_en_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| level_i | input | 4 | Encoded interrupt level: 0 means none, 15 is the most urgent |
| src_assert_o | output | 15 | Request for each chain position |
| src_force_en_o | output | 15 | Sticky enable override for each chain position |

## Verification
The bench walks through all fifteen nonzero codes. A decoder that used the code itself, rather than its complement, would light bit L instead of bit 15-L. The same decoder would put code 0 on a real position instead of leaving all requests off.

It switches directly between two nonzero codes. A design that set request bits without clearing the old one would show two bits at once.

It checks that the enable override survives a release and a return to code 0, and that it clears only on reset. A design that tied the enable to the request would lose it.

It also samples just after the level input changes and before the next edge. A combinational path from level to outputs would show the new value there.

// File: rtl/enc_lvl_pkg.sv
package enc_lvl_pkg;
  // Number of chain positions reachable from a level code of the given width.
  // The all-ones index is reserved as "no position".
  function automatic int src_count(input int level_w);
    return (1 << level_w) - 1;
  endfunction
endpackage

// File: rtl/enc_lvl_decode.sv
module enc_lvl_decode #(
  parameter int LEVEL_W = 4,
  parameter int NUM_SRC = enc_lvl_pkg::src_count(LEVEL_W)
) (
  input  logic [LEVEL_W-1:0] level_i,
  output logic [NUM_SRC-1:0] sel_o,
  output logic               sel_none_o
);
  // Chain position is the complement of the level code.
  function automatic logic [LEVEL_W-1:0] chain_index(input logic [LEVEL_W-1:0] lvl);
    return lvl ^ {LEVEL_W{1'b1}};
  endfunction

  logic [LEVEL_W-1:0] idx;
  assign idx = chain_index(level_i);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    assign sel_o[i] = (idx == LEVEL_W'(i));
  end

  // Index equal to NUM_SRC (all ones) lies past the chain: code 0.
  assign sel_none_o = (idx == LEVEL_W'(NUM_SRC));
endmodule

// File: rtl/enc_lvl_cell.sv
module enc_lvl_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  output logic assert_o,
  output logic force_en_o
);
  logic assert_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      assert_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      assert_q <= sel_i;
      en_q     <= en_q | sel_i;
    end
  end

  assign assert_o   = assert_q;
  assign force_en_o = en_q;

  // R2
  sel_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i |=> assert_o);

  // R7
  unsel_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !assert_o);

  // R6
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_en_o |=> force_en_o);

  // R6
  assert_has_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    assert_o |-> force_en_o);
endmodule

// File: rtl/enc_level_decoder.sv
module enc_level_decoder #(
  parameter int LEVEL_W = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [LEVEL_W-1:0]                          level_i,
  output logic [enc_lvl_pkg::src_count(LEVEL_W)-1:0] src_assert_o,
  output logic [enc_lvl_pkg::src_count(LEVEL_W)-1:0] src_force_en_o
);
  localparam int NUM_SRC = enc_lvl_pkg::src_count(LEVEL_W);

  logic [NUM_SRC-1:0] sel;
  logic               sel_none;

  enc_lvl_decode #(.LEVEL_W(LEVEL_W), .NUM_SRC(NUM_SRC)) decode_i (
    .level_i   (level_i),
    .sel_o     (sel),
    .sel_none_o(sel_none)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    enc_lvl_cell cell_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (sel[i]),
      .assert_o  (src_assert_o[i]),
      .force_en_o(src_force_en_o[i])
    );
  end

  // R4
  single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_assert_o));

  // R3
  level_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_none |=> (src_assert_o == '0));

  // R8
  zero_keeps_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_none |=> $stable(src_force_en_o));

  // R5
  steady_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(level_i) && $past(rst_n)) |=> $stable(src_assert_o));
endmodule

// File: tb/enc_level_decoder_tb.sv
module enc_level_decoder_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  level = 4'd0;
  logic [14:0] src_assert;
  logic [14:0] src_en;

  int n_checks = 0;
  int n_fail = 0;
  logic [14:0] exp_en = '0;

  always #5 clk = ~clk;

  enc_level_decoder #(.LEVEL_W(4)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .level_i       (level),
    .src_assert_o  (src_assert),
    .src_force_en_o(src_en)
  );

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected bit for a nonzero code: position counted from the top end.
  function automatic logic [14:0] exp_vec(input int lvl);
    logic [14:0] v = '0;
    if (lvl != 0) v[15 - lvl] = 1'b1;
    return v;
  endfunction

  // Drive at a falling edge, sample at the next falling edge.
  task automatic step(input int lvl);
    level = lvl[3:0];
    @(negedge clk);
    if (lvl != 0) exp_en = exp_en | exp_vec(lvl);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    level = 4'd0;
    #1;
    check("R1 assert in reset", src_assert, '0);
    check("R1 enable in reset", src_en, '0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_en = '0;
    @(negedge clk);
    check("R1 assert after reset", src_assert, '0);
    check("R1 enable after reset", src_en, '0);
  endtask

  task automatic t_all_levels();
    for (int l = 1; l <= 15; l++) begin
      step(l);
      check("R2 level select", src_assert, exp_vec(l));
    end
    check("R2 code 15 hits bit 0", exp_vec(15), 15'h0001);
  endtask

  task automatic t_level_zero();
    step(9);
    step(0);
    check("R3 zero clears requests", src_assert, '0);
  endtask

  task automatic t_switch();
    step(7);
    check("R7 first code", src_assert, exp_vec(7));
    step(3);
    check("R7 switch drops old", src_assert, exp_vec(3));
    check("R4 single request", 15'($countones(src_assert)), 15'd1);
  endtask

  task automatic t_timing();
    step(12);
    level = 4'd2;
    #2;
    check("R5 no change before edge", src_assert, exp_vec(12));
    @(negedge clk);
    exp_en = exp_en | exp_vec(2);
    check("R5 change after edge", src_assert, exp_vec(2));
    step(2);
    step(2);
    check("R5 steady level", src_assert, exp_vec(2));
  endtask

  task automatic t_sticky_enable();
    do_reset();
    step(15);
    step(1);
    step(0);
    check("R6 enable kept after release", src_en, 15'h4001);
    check("R8 untouched enables zero", src_en & ~15'h4001, '0);
    step(0);
    check("R8 zero leaves enables", src_en, exp_en);
    do_reset();
    check("R6 enable cleared by reset", src_en, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_all_levels();
    t_level_zero();
    t_switch();
    t_timing();
    check("R6 accumulated enables", src_en, exp_en);
    t_sticky_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule